// File: doc/BRIEF.md
# Windowed Limit Interrupt Controller

This block watches a set of measurement channels: four analog-input conversion results, an internal temperature result, an external temperature result and a supply-voltage result, all 10 bits wide, plus a one-bit diode-fault indication. Each channel has its own valid strobe. On every strobe, the 8 most significant bits of the result are compared against that channel's 8-bit high and low limits. A result outside the window sets a sticky status flag, unless the channel's mask bit is set.

A single interrupt pin reports whether any unmasked flag is pending. A configuration register enables the pin and selects whether it is active high or active low. Software reaches the limits, masks, configuration and the two status registers through a simple register port. Reading a status register clears the flags it holds. A software-reset bit in the configuration register clears every flag at once.

Register map (5-bit address, 8-bit data): 0x00 analog-input status, 0x01 second status, 0x02 analog-input mask, 0x03 second mask, 0x04 configuration, 0x05..0x0B high limits for channels 0..6, 0x0C..0x12 low limits for channels 0..6. Channels 0..3 are analog inputs 1..4, channel 4 is internal temperature, channel 5 is external temperature and channel 6 is supply.

Top module: `limit_irq_ctrl`

## Requirements
- R1: A strobed result whose top 8 bits are strictly greater than the channel's high limit sets its flag. Equality with the high limit does not set it.
- R2: A strobed result whose top 8 bits are less than or equal to the channel's low limit sets its flag.
- R3: Only result bits [9:2] take part in the comparison, so the two low bits have no effect.
- R4: When a channel's mask bit is 1, its flag is never set and the interrupt pin does not react to it. Each mask register holds one bit per flag, in the same bit positions as the status register it guards.
- R5: Status register 0x00 holds analog inputs 1..4 in bits 0..3. Status register 0x01 holds internal temperature in bit 0, external temperature in bit 1, supply in bit 2 and diode fault in bit 3. A diode-fault flag is raised when its strobe is high and the fault input is 1. Unused bits read 0.
- R6: Configuration bit 0 enables the pin and bit 1 selects its polarity (1 = active high, 0 = active low). With the pin enabled, it is at its active level whenever any unmasked flag is set.
- R7: With configuration bit 0 clear, the pin stays at its inactive level (the inverse of bit 1), even while flags are pending.
- R8: A read of a status register returns the flags it holds and clears them after that cycle. The other status register is left untouched.
- R9: Writing configuration bit 2 as 1 clears all flags in both status registers. The bit itself is not stored and reads back as 0.
- R10: When a flag's set condition coincides with a clearing read, the flag remains set afterwards.
- R11: A channel is compared only in cycles where its valid strobe is high. A result held without a strobe sets nothing.
- R12: After reset, both masks read 0x0F, all high limits read 0xFF, all low limits read 0x00, and configuration reads 0x00 (pin disabled, active low). Register reads are combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ain_res | input | 40 | Four analog-input results, channel n at bits [10n+9:10n] |
| ain_vld | input | 4 | Valid strobes for the analog inputs |
| tint_res | input | 10 | Internal temperature result |
| tint_vld | input | 1 | Internal temperature strobe |
| text_res | input | 10 | External temperature result |
| text_vld | input | 1 | External temperature strobe |
| vsup_res | input | 10 | Supply-voltage result |
| vsup_vld | input | 1 | Supply strobe |
| dflt | input | 1 | Diode-fault indication |
| dflt_vld | input | 1 | Diode-fault strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on read) |
| addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The comparison is probed with results placed exactly on each limit, one LSB of the top byte beyond it, and with only the two discarded low bits changed. These patterns separate a strict test from an inclusive one on each side and show the bits used in the comparison. Results held without a strobe, masked sources and a strobe coinciding with a clearing read show when a flag must not change or must survive. Both status registers are filled at once and then read alternately, which shows the flag placement and that each read clears only its own register. The pin is checked under both polarities with the enable set and clear.

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl #(
  parameter int AIN_N  = 4,
  parameter int RES_W  = 10,
  parameter int LIM_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AIN_N*RES_W-1:0] ain_res,
  input  logic [AIN_N-1:0]       ain_vld,
  input  logic [RES_W-1:0]       tint_res,
  input  logic                   tint_vld,
  input  logic [RES_W-1:0]       text_res,
  input  logic                   text_vld,
  input  logic [RES_W-1:0]       vsup_res,
  input  logic                   vsup_vld,
  input  logic                   dflt,
  input  logic                   dflt_vld,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LIM_W-1:0]       wr_data,
  output logic [LIM_W-1:0]       rd_data,
  output logic                   irq_pin
);

  localparam int NCH = AIN_N + 3;
  localparam int NB  = 4;
  localparam int SH  = RES_W - LIM_W;
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MKA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MKB = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4);
  localparam int A_HI = 5;
  localparam int A_LO = A_HI + NCH;

  logic [NCH*RES_W-1:0] res;
  logic [NCH-1:0]       vld;
  logic [NCH-1:0]       oor;
  logic [LIM_W-1:0]     hi_q [NCH];
  logic [LIM_W-1:0]     lo_q [NCH];
  logic [AIN_N-1:0]     sta_a, mask_a, set_a;
  logic [NB-1:0]        sta_b, mask_b, set_b;
  logic                 cfg_en, cfg_pol;
  logic                 swrst, clr_a, clr_b, active;

  assign res = {vsup_res, text_res, tint_res, ain_res};
  assign vld = {vsup_vld, text_vld, tint_vld, ain_vld};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [LIM_W-1:0] top;
    assign top     = res[ch*RES_W+SH +: LIM_W];
    assign oor[ch] = vld[ch] && ((top > hi_q[ch]) || (top <= lo_q[ch]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[ch] <= '1;
        lo_q[ch] <= '0;
      end else if (wr_en) begin
        if (addr == ADDR_W'(A_HI + ch)) hi_q[ch] <= wr_data;
        if (addr == ADDR_W'(A_LO + ch)) lo_q[ch] <= wr_data;
      end
    end
  end

  assign set_a = oor[AIN_N-1:0] & ~mask_a;
  assign set_b = {dflt_vld & dflt, oor[NCH-1:AIN_N]} & ~mask_b;
  assign swrst = wr_en && (addr == A_CFG) && wr_data[2];
  assign clr_a = (rd_en && (addr == A_STA)) || swrst;
  assign clr_b = (rd_en && (addr == A_STB)) || swrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_a   <= '0;
      sta_b   <= '0;
      mask_a  <= '1;
      mask_b  <= '1;
      cfg_en  <= 1'b0;
      cfg_pol <= 1'b0;
    end else begin
      sta_a <= (clr_a ? '0 : sta_a) | set_a;
      sta_b <= (clr_b ? '0 : sta_b) | set_b;
      if (wr_en && addr == A_MKA) mask_a <= wr_data[AIN_N-1:0];
      if (wr_en && addr == A_MKB) mask_b <= wr_data[NB-1:0];
      if (wr_en && addr == A_CFG) begin
        cfg_en  <= wr_data[0];
        cfg_pol <= wr_data[1];
      end
    end
  end

  assign active  = cfg_en && (|(sta_a & ~mask_a) || |(sta_b & ~mask_b));
  assign irq_pin = cfg_pol ? active : ~active;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_STA:   rd_data = LIM_W'(sta_a);
      A_STB:   rd_data = LIM_W'(sta_b);
      A_MKA:   rd_data = LIM_W'(mask_a);
      A_MKB:   rd_data = LIM_W'(mask_b);
      A_CFG:   rd_data = LIM_W'({cfg_pol, cfg_en});
      default: begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (addr == ADDR_W'(A_HI + ch)) rd_data = hi_q[ch];
          if (addr == ADDR_W'(A_LO + ch)) rd_data = lo_q[ch];
        end
      end
    endcase
  end

endmodule

// File: rtl/limit_irq_ctrl_chk.sv
module limit_irq_ctrl_chk #(
  parameter int AIN_N  = 4,
  parameter int LIM_W  = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [LIM_W-1:0]  wr_data,
  input logic              irq_pin,
  input logic              cfg_en,
  input logic              cfg_pol,
  input logic [AIN_N-1:0]  mask_a,
  input logic [3:0]        mask_b,
  input logic [AIN_N-1:0]  sta_a,
  input logic [3:0]        sta_b,
  input logic [AIN_N-1:0]  set_a,
  input logic [3:0]        set_b
);

  // R4
  masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sta_a & ~$past(sta_a) & $past(mask_a)) == '0) &&
              ((sta_b & ~$past(sta_b) & $past(mask_b)) == '0)));

  // R6
  pin_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && (|(sta_a & ~mask_a) || |(sta_b & ~mask_b))) |-> (irq_pin == cfg_pol));

  // R7
  pin_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (irq_pin == !cfg_pol));

  // R10
  keep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_a || |set_b) |=> (((sta_a & $past(set_a)) == $past(set_a)) &&
                            ((sta_b & $past(set_b)) == $past(set_b))));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(0) && set_a == '0) |=> (sta_a == '0));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && wr_data[2] && set_a == '0 && set_b == '0)
      |=> (sta_a == '0 && sta_b == '0));

endmodule

bind limit_irq_ctrl limit_irq_ctrl_chk #(.AIN_N(AIN_N), .LIM_W(LIM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .irq_pin(irq_pin), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
  .mask_a(mask_a), .mask_b(mask_b), .sta_a(sta_a), .sta_b(sta_b),
  .set_a(set_a), .set_b(set_b)
);

// File: tb/test_limit_irq_ctrl.sv
module test_limit_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] ain_res = '0;
  logic [3:0]  ain_vld = '0;
  logic [9:0]  tint_res = '0, text_res = '0, vsup_res = '0;
  logic        tint_vld = 0, text_vld = 0, vsup_vld = 0;
  logic        dflt = 0, dflt_vld = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_pin;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  limit_irq_ctrl i_limit_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ain_res(ain_res), .ain_vld(ain_vld),
    .tint_res(tint_res), .tint_vld(tint_vld), .text_res(text_res), .text_vld(text_vld),
    .vsup_res(vsup_res), .vsup_vld(vsup_vld), .dflt(dflt), .dflt_vld(dflt_vld),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_pin(irq_pin)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // monitor: pops one expected item per read cycle
  initial forever begin
    @(negedge clk);
    #1;
    if (rd_en) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %02h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s addr %02h: actual %02h expected %02h", t, addr, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic meas(input int ch, input logic [9:0] v);
    @(negedge clk);
    case (ch)
      4: begin tint_res = v; tint_vld = 1; end
      5: begin text_res = v; text_vld = 1; end
      6: begin vsup_res = v; vsup_vld = 1; end
      default: begin ain_res[ch*10 +: 10] = v; ain_vld[ch] = 1; end
    endcase
    @(negedge clk);
    ain_vld = '0; tint_vld = 0; text_vld = 0; vsup_vld = 0;
  endtask

  task automatic chk_pin(input logic e, input string t);
    #1;
    n_vec++;
    if (irq_pin !== e) begin
      n_bad++;
      $display("FAIL %s pin: actual %0b expected %0b", t, irq_pin, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset values
    chk_pin(1'b1, "R12");
    rd(5'h02, 8'h0F, "R12");
    rd(5'h03, 8'h0F, "R12");
    rd(5'h04, 8'h00, "R12");
    rd(5'h05, 8'hFF, "R12");
    rd(5'h0B, 8'hFF, "R12");
    rd(5'h0C, 8'h00, "R12");
    rd(5'h00, 8'h00, "R12");

    wr(5'h02, 8'h00);
    wr(5'h03, 8'h00);
    wr(5'h04, 8'h01);
    wr(5'h05, 8'h80);
    wr(5'h0C, 8'h20);
    // R3: 0x203 -> top 0x80, equal to high, no flag
    meas(0, 10'h203);
    rd(5'h00, 8'h00, "R3");
    // R1: equal 0x200 no flag, 0x204 -> top 0x81 flags
    meas(0, 10'h200);
    rd(5'h00, 8'h00, "R1");
    meas(0, 10'h204);
    chk_pin(1'b0, "R6");
    rd(5'h00, 8'h01, "R1");
    chk_pin(1'b1, "R8");
    // R2 on channel 1, low limit 0x40
    wr(5'h0D, 8'h40);
    meas(1, 10'h100);
    rd(5'h00, 8'h02, "R2");
    meas(1, 10'h104);
    rd(5'h00, 8'h00, "R2");
    // R11: result below low limit held without strobe
    @(negedge clk);
    ain_res[20 +: 10] = 10'h000;
    repeat (3) @(negedge clk);
    rd(5'h00, 8'h00, "R11");
    // R5 / R8: fill both status registers
    meas(3, 10'h000);
    meas(4, 10'h000);
    meas(5, 10'h000);
    meas(6, 10'h000);
    @(negedge clk);
    dflt = 1; dflt_vld = 1;
    @(negedge clk);
    dflt = 0; dflt_vld = 0;
    rd(5'h00, 8'h08, "R5");
    rd(5'h01, 8'h0F, "R5");
    rd(5'h00, 8'h00, "R8");
    rd(5'h01, 8'h00, "R8");
    // R4: masked internal temperature
    wr(5'h03, 8'h01);
    meas(4, 10'h000);
    chk_pin(1'b1, "R4");
    rd(5'h01, 8'h00, "R4");
    // R6 active-high, R7 disable
    wr(5'h04, 8'h03);
    meas(0, 10'h204);
    chk_pin(1'b1, "R6");
    wr(5'h04, 8'h02);
    chk_pin(1'b0, "R7");
    rd(5'h00, 8'h01, "R7");
    // R9 software reset
    wr(5'h04, 8'h03);
    meas(0, 10'h204);
    meas(3, 10'h000);
    chk_pin(1'b1, "R9");
    wr(5'h04, 8'h07);
    chk_pin(1'b0, "R9");
    rd(5'h04, 8'h03, "R9");
    rd(5'h00, 8'h00, "R9");
    // R10: event during clearing read
    @(negedge clk);
    exp_q.push_back(8'h00); tag_q.push_back("R10");
    rd_en = 1; addr = 5'h00;
    ain_res[0 +: 10] = 10'h204; ain_vld[0] = 1;
    @(negedge clk);
    rd_en = 0; ain_vld = '0;
    chk_pin(1'b1, "R10");
    rd(5'h00, 8'h01, "R10");
    @(negedge clk);
    finish_run();
  end
endmodule